// File: doc/BRIEF.md
# Pulse Descriptor Capture and Parity Word Emitter

This block keeps the last accepted set of measurements for one received radar pulse and hands it on as a run of 32-bit words. The measurements are arrival time, pulse width, carrier frequency, leading- and trailing-edge frequency, amplitude, bearing, intra-pulse flags and self-test bits. On a capture strobe the block packs them into a six-word (192-bit) descriptor register. It does so only if none of four qualifying flags is raised. The four flags are pulse-on-pulse, pulse-on-continuous-wave, bearing fault and width fault. If any of them is set, the previous descriptor stays in place.

A separate transfer sequencer drives a presence level, a one-cycle word strobe, a 3-bit word address and an end-of-transfer level. Each accepted strobe makes the block present the addressed word on a 33-bit bus for one cycle, flagged by `out_valid`. Bit 32 of the bus carries the XOR of the 32 data bits, so each emitted word has even parity. Data only flows out of the block. There is no ready input and no back-pressure: the consumer must take each word in the cycle `out_valid` is high, and the sequencer paces the words.

Top module: `sig_desc_packer`

## Requirements
- R1: After reset `word_out` is zero, `out_valid` is low, and every descriptor word reads back as zero.
- R2: When `capture_stb` is high at a clock edge and all four inhibit flags are low, the descriptor takes the current field inputs at that edge.
- R3: When `capture_stb` is high at an edge and any one of `flag_pop`, `flag_pocw`, `flag_dir_bad` or `flag_width_bad` is high, the descriptor keeps its previous contents.
- R4: An edge that samples `word_clk`, `present` high and `end_xfer` low loads the addressed word into `word_out`, and `out_valid` is high for exactly the following cycle.
- R5: Word 0 holds `toa[31:0]`. Word 1 holds `toa[35:32]` in bits 3:0 and `pw` in bits 16:4, with its upper bits zero.
- R6: Word 2 holds `freq` in bits 11:0 and `freq_lead` in bits 23:12. Word 3 holds `freq_trail` in bits 11:0 and `amp` in bits 19:12. Their upper bits are zero.
- R7: Word 4 holds `dir` in bits 9:0. Word 5 holds `intra_flags` in bits 3:0 and `bite_bits` in bits 7:4. All other bits of both words are zero.
- R8: Addresses 6 and 7 emit an all-zero word with parity bit zero, and `out_valid` is still high.
- R9: `word_out[32]` equals the XOR of `word_out[31:0]`.
- R10: An edge that samples `present` low clears `word_out` to zero and emits nothing, whatever `word_clk` does.
- R11: An edge that samples `end_xfer` high clears `word_out` to zero and emits nothing.
- R12: While `present` is high and no word strobe arrives, `word_out` keeps the last emitted word and `out_valid` is low.
- R13: If a capture and a word strobe share an edge, the emitted word comes from the descriptor as it was before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_stb | input | 1 | Capture strobe for the descriptor |
| flag_pop | input | 1 | Pulse-on-pulse inhibit flag |
| flag_pocw | input | 1 | Pulse-on-continuous-wave inhibit flag |
| flag_dir_bad | input | 1 | Bearing fault inhibit flag |
| flag_width_bad | input | 1 | Width fault inhibit flag |
| toa | input | 36 | Arrival time |
| pw | input | 13 | Pulse width |
| freq | input | 12 | Carrier frequency |
| freq_lead | input | 12 | Leading-edge frequency |
| freq_trail | input | 12 | Trailing-edge frequency |
| amp | input | 8 | Amplitude |
| dir | input | 10 | Bearing |
| intra_flags | input | 4 | Intra-pulse condition flags |
| bite_bits | input | 4 | Built-in-test bits |
| present | input | 1 | Transfer presence level |
| word_clk | input | 1 | One-cycle word strobe |
| word_addr | input | 3 | Word index |
| end_xfer | input | 1 | End-of-transfer level |
| word_out | output | 33 | Parity bit (32) and data word (31:0) |
| out_valid | output | 1 | High for the cycle a word is presented |

## Verification
The bench raises each inhibit flag alone during a capture. It then reads the descriptor back to show that the old contents survived. A design that used only some of the flags in the OR would overwrite the descriptor in this test. All eight addresses are read after captures with distinct and all-ones patterns. A wrong field offset then shows up as a misplaced bit, and a missing zero word at the two spare addresses shows up as stale data. Word strobes are also sent with `present` low and with `end_xfer` high, where a design that failed to gate the output would emit an unexpected word. A capture is also placed on the same edge as a read, which catches a design that forwards the new fields into the word being read.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 6;
  localparam int ADDR_W    = 3;
  localparam int BUS_W     = WORD_W + 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] desc_t;
endpackage

// File: rtl/sdp_field_pack.sv
module sdp_field_pack
  import sdp_pkg::*;
#(
  parameter int TOA_W  = 36,
  parameter int PW_W   = 13,
  parameter int FREQ_W = 12,
  parameter int AMP_W  = 8,
  parameter int DIR_W  = 10,
  parameter int FLAG_W = 4,
  parameter int BIT_W  = 4
) (
  input  logic [TOA_W-1:0]  toa,
  input  logic [PW_W-1:0]   pw,
  input  logic [FREQ_W-1:0] freq,
  input  logic [FREQ_W-1:0] freq_lead,
  input  logic [FREQ_W-1:0] freq_trail,
  input  logic [AMP_W-1:0]  amp,
  input  logic [DIR_W-1:0]  dir,
  input  logic [FLAG_W-1:0] intra_flags,
  input  logic [BIT_W-1:0]  bite_bits,
  output desc_t             desc_nxt
);
  localparam int TOA_HI = TOA_W - WORD_W;

  always_comb begin
    desc_nxt    = '0;
    desc_nxt[0] = toa[WORD_W-1:0];
    desc_nxt[1] = WORD_W'(toa[TOA_W-1:WORD_W]) | (WORD_W'(pw) << TOA_HI);
    desc_nxt[2] = WORD_W'(freq) | (WORD_W'(freq_lead) << FREQ_W);
    desc_nxt[3] = WORD_W'(freq_trail) | (WORD_W'(amp) << FREQ_W);
    desc_nxt[4] = WORD_W'(dir);
    desc_nxt[5] = WORD_W'(intra_flags) | (WORD_W'(bite_bits) << FLAG_W);
  end
endmodule

// File: rtl/sdp_desc_store.sv
module sdp_desc_store
  import sdp_pkg::*;
#(
  parameter int INH_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture_stb,
  input  logic [INH_W-1:0] inhibit_flags,
  input  desc_t            desc_nxt,
  output desc_t            desc_q
);
  logic take;
  assign take = capture_stb & ~(|inhibit_flags);

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)    desc_q[gi] <= '0;
      else if (take) desc_q[gi] <= desc_nxt[gi];
    end
  end
endmodule

// File: rtl/sdp_word_mux.sv
module sdp_word_mux
  import sdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  desc_t             desc_q,
  input  logic              present,
  input  logic              word_clk,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              end_xfer,
  output logic [BUS_W-1:0]  word_out,
  output logic              out_valid
);
  word_t sel;
  logic  emit, clear;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (word_addr == ADDR_W'(i)) sel = desc_q[i];
  end

  assign emit  = present & word_clk & ~end_xfer;
  assign clear = ~present | end_xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_out  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      if (clear)     word_out <= '0;
      else if (emit) word_out <= {^sel, sel};
    end
  end
endmodule

// File: rtl/sig_desc_packer.sv
module sig_desc_packer
  import sdp_pkg::*;
#(
  parameter int TOA_W  = 36,
  parameter int PW_W   = 13,
  parameter int FREQ_W = 12,
  parameter int AMP_W  = 8,
  parameter int DIR_W  = 10,
  parameter int FLAG_W = 4,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_stb,
  input  logic              flag_pop,
  input  logic              flag_pocw,
  input  logic              flag_dir_bad,
  input  logic              flag_width_bad,
  input  logic [TOA_W-1:0]  toa,
  input  logic [PW_W-1:0]   pw,
  input  logic [FREQ_W-1:0] freq,
  input  logic [FREQ_W-1:0] freq_lead,
  input  logic [FREQ_W-1:0] freq_trail,
  input  logic [AMP_W-1:0]  amp,
  input  logic [DIR_W-1:0]  dir,
  input  logic [FLAG_W-1:0] intra_flags,
  input  logic [BIT_W-1:0]  bite_bits,
  input  logic              present,
  input  logic              word_clk,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              end_xfer,
  output logic [BUS_W-1:0]  word_out,
  output logic              out_valid
);
  desc_t desc_nxt, desc_q;

  sdp_field_pack #(
    .TOA_W(TOA_W), .PW_W(PW_W), .FREQ_W(FREQ_W), .AMP_W(AMP_W),
    .DIR_W(DIR_W), .FLAG_W(FLAG_W), .BIT_W(BIT_W)
  ) u_pack (
    .toa(toa), .pw(pw), .freq(freq), .freq_lead(freq_lead),
    .freq_trail(freq_trail), .amp(amp), .dir(dir),
    .intra_flags(intra_flags), .bite_bits(bite_bits), .desc_nxt(desc_nxt)
  );

  sdp_desc_store #(.INH_W(4)) u_store (
    .clk(clk), .rst_n(rst_n), .capture_stb(capture_stb),
    .inhibit_flags({flag_pop, flag_pocw, flag_dir_bad, flag_width_bad}),
    .desc_nxt(desc_nxt), .desc_q(desc_q)
  );

  sdp_word_mux u_mux (
    .clk(clk), .rst_n(rst_n), .desc_q(desc_q), .present(present),
    .word_clk(word_clk), .word_addr(word_addr), .end_xfer(end_xfer),
    .word_out(word_out), .out_valid(out_valid)
  );
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker
  import sdp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              present,
  input logic              word_clk,
  input logic [ADDR_W-1:0] word_addr,
  input logic              end_xfer,
  input logic [BUS_W-1:0]  word_out,
  input logic              out_valid
);
  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ^word_out == 1'b0); // R9
  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(word_clk && present && !end_xfer)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !present |=> (word_out == '0 && !out_valid)); // R10
  AST_EOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    end_xfer |=> (word_out == '0 && !out_valid)); // R11
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word_clk && present && !end_xfer && word_addr >= ADDR_W'(NUM_WORDS))
    |=> (word_out == '0 && out_valid)); // R8
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (present && !word_clk && !end_xfer) |=> (!out_valid && $stable(word_out))); // R12
endmodule

bind sig_desc_packer sdp_checker u_chk (.*);

// File: tb/tb_sig_desc_packer.sv
`timescale 1ns/1ps
module tb_sig_desc_packer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic capture_stb = 0, flag_pop = 0, flag_pocw = 0, flag_dir_bad = 0, flag_width_bad = 0;
  logic [35:0] toa = '0;
  logic [12:0] pw = '0;
  logic [11:0] freq = '0, freq_lead = '0, freq_trail = '0;
  logic [7:0]  amp = '0;
  logic [9:0]  dir = '0;
  logic [3:0]  intra_flags = '0, bite_bits = '0;
  logic present = 0, word_clk = 0, end_xfer = 0;
  logic [2:0]  word_addr = '0;
  logic [32:0] word_out;
  logic        out_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [32:0] expq[$];
  string tagq[$];

  // model of latched fields
  logic [35:0] m_toa = '0; logic [12:0] m_pw = '0;
  logic [11:0] m_freq = '0, m_lead = '0, m_trail = '0;
  logic [7:0] m_amp = '0; logic [9:0] m_dir = '0;
  logic [3:0] m_intra = '0, m_bite = '0;

  sig_desc_packer dut (.*);

  always #2 clk = ~clk;

  function automatic logic [32:0] exp_word(input int a);
    logic [31:0] w;
    case (a)
      0: w = m_toa[31:0];
      1: w = {15'b0, m_pw, m_toa[35:32]};
      2: w = {8'b0, m_lead, m_freq};
      3: w = {12'b0, m_amp, m_trail};
      4: w = {22'b0, m_dir};
      5: w = {24'b0, m_bite, m_intra};
      default: w = '0;
    endcase
    return {^w, w};
  endfunction

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_fields(input logic [35:0] t, input logic [12:0] p, input logic [11:0] f,
                            input logic [11:0] fl, input logic [11:0] ft, input logic [7:0] a,
                            input logic [9:0] d, input logic [3:0] ia, input logic [3:0] bb);
    toa = t; pw = p; freq = f; freq_lead = fl; freq_trail = ft; amp = a; dir = d;
    intra_flags = ia; bite_bits = bb;
  endtask

  task automatic latch_model();
    m_toa = toa; m_pw = pw; m_freq = freq; m_lead = freq_lead; m_trail = freq_trail;
    m_amp = amp; m_dir = dir; m_intra = intra_flags; m_bite = bite_bits;
  endtask

  // drive one capture; flags = {pop,pocw,dir_bad,width_bad}
  task automatic do_capture(input logic [3:0] flags);
    @(negedge clk);
    {flag_pop, flag_pocw, flag_dir_bad, flag_width_bad} = flags;
    capture_stb = 1;
    if (flags == 4'b0) latch_model(); // R2; otherwise R3: model unchanged
    @(negedge clk);
    capture_stb = 0;
    {flag_pop, flag_pocw, flag_dir_bad, flag_width_bad} = 4'b0;
  endtask

  // driver: push expected word, pulse the strobe
  task automatic read_word(input int a, input string tag);
    @(negedge clk);
    word_addr = 3'(a);
    word_clk = 1;
    expq.push_back(exp_word(a));
    tagq.push_back(tag);
    @(negedge clk);
    word_clk = 0;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 8; a++) read_word(a, tag);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (expq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R4 unexpected word actual=%h expected=none", word_out);
        end else begin
          automatic logic [32:0] e = expq.pop_front();
          automatic string t = tagq.pop_front();
          chk(t, word_out, e);
          chk("R9 parity", {32'b0, ^word_out[31:0]}, {32'b0, word_out[32]});
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [32:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 word_out reset", word_out, '0);
    chk("R1 out_valid reset", {32'b0, out_valid}, 33'b0);
    present = 1;
    read_all("R1 zero descriptor");

    set_fields(36'hA_1234_5678, 13'h1ABC, 12'h123, 12'h456, 12'h789, 8'hC5, 10'h2F1, 4'h9, 4'h6);
    do_capture(4'b0000);
    read_all("R2 R5 R6 R7 R8 pattern A");

    set_fields(36'h5_DEAD_BEEF, 13'h0F0F, 12'hABC, 12'hDEF, 12'h321, 8'h3A, 10'h155, 4'h3, 4'hC);
    for (int f = 0; f < 4; f++) begin
      do_capture(4'b1 << f);
      read_word(f, "R3 inhibit keeps old");
    end
    read_all("R3 descriptor unchanged");

    do_capture(4'b0000);
    read_all("R2 R5 R6 R7 pattern B");

    set_fields('1, '1, '1, '1, '1, '1, '1, '1, '1);
    do_capture(4'b0000);
    read_all("R5 R6 R7 R9 all ones");

    // R12 hold between strobes
    read_word(3, "R12 prior word");
    held = exp_word(3);
    repeat (3) @(negedge clk);
    chk("R12 hold word", word_out, held);
    chk("R12 valid low", {32'b0, out_valid}, 33'b0);

    // R13 capture and read on the same edge
    set_fields(36'h0_0000_0011, 13'h0002, 12'h003, 12'h004, 12'h005, 8'h06, 10'h007, 4'h8, 4'h1);
    @(negedge clk);
    capture_stb = 1; word_clk = 1; word_addr = 3'd0;
    expq.push_back(exp_word(0)); tagq.push_back("R13 old contents");
    latch_model();
    @(negedge clk);
    capture_stb = 0; word_clk = 0;
    read_word(0, "R13 new contents later");

    // R10 present low ignores strobe
    @(negedge clk);
    present = 0; word_clk = 1; word_addr = 3'd2;
    @(negedge clk);
    chk("R10 word_out zero", word_out, '0);
    chk("R10 no valid", {32'b0, out_valid}, 33'b0);
    word_clk = 0;
    present = 1;
    read_word(1, "R4 after present returns");

    // R11 end of transfer
    @(negedge clk);
    end_xfer = 1; word_clk = 1; word_addr = 3'd4;
    @(negedge clk);
    chk("R11 word_out zero", word_out, '0);
    chk("R11 no valid", {32'b0, out_valid}, 33'b0);
    word_clk = 0; end_xfer = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R4 missing words actual=%0d pending expected=0", expq.size());
    end
    finish_run();
  end
endmodule